// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a small system through four power modes: full-speed (NORMAL), reduced clock (SLOW), core-clock-stopped (IDLE) and powered-down (SLEEP). Software drives level and pulse request inputs. The CPU confirms an idle request with an acknowledge. Sixteen external wake lines, an alarm and a combined interrupt line bring the system out of the low-power modes. The block runs from the free-running crystal clock. It tells the clock and power network when the PLL may run, whether the PLL output is usable, which clock source feeds the system, and whether the core is clocked and powered. After a wake from SLEEP it holds the core in a fixed-length internal reset.

The states are named as follows. ST_LOCK waits for the PLL to lock. ST_NORMAL and ST_SLOW are the two running modes. ST_IDLE_WAIT waits for the CPU acknowledge, and ST_IDLE is the stopped-core mode. ST_SLEEP is the powered-down mode, and ST_WAKE_RST holds the internal reset.

The transitions are these. Reset enters ST_LOCK. When the lock count ends, ST_LOCK goes to ST_SLOW if the slow request is set and to ST_NORMAL if it is clear. ST_NORMAL goes to ST_SLEEP, ST_IDLE_WAIT or ST_SLOW, in that order of priority. ST_SLOW also goes to ST_SLEEP or ST_IDLE_WAIT. From ST_SLOW, a PLL turned back on leads to ST_LOCK, and a cleared slow request with the PLL running leads to ST_NORMAL. ST_IDLE_WAIT goes to ST_IDLE on the acknowledge. ST_IDLE returns to the running mode it came from when a wake source fires. ST_SLEEP goes to ST_WAKE_RST on a qualified wake line. ST_WAKE_RST goes to ST_LOCK when its count ends.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is held and right after it, the block is in the lock phase. In that phase mode = 1, clk_sel_slow = 1, pll_en = 1, pll_stable = 0, core_clk_en = 1, core_pwr_en = 1, int_rst = 0, woke_from_sleep = 0 and bfault_irq = 0.
- R2: Each time the PLL is switched on (out of reset, after a wake, or by dropping req_pll_off in SLOW), the slow source stays selected and pll_stable stays 0 for exactly max(lock_count,1) cycles. After that, pll_stable reads 1.
- R3: mode is coded as 0 = NORMAL, 1 = SLOW (this includes the lock phase), 2 = IDLE, 3 = SLEEP (this includes the wake reset). Raising req_slow in NORMAL gives mode 1 and clk_sel_slow = 1 one cycle later. Clearing req_slow in SLOW with the PLL stable gives mode 0 and clk_sel_slow = 0 one cycle later.
- R4: req_pll_off drops pll_en only in SLOW, and it has no effect in any other mode. While the PLL is off, clearing req_slow leaves the block in SLOW.
- R5: A pulse on req_idle keeps core_clk_en at 1 until cpu_idle_ack is seen. One cycle after the acknowledge, core_clk_en = 0 and mode = 2.
- R6: IDLE ends on irq_any, on alarm_wake, or on a qualified wake line whose wake_en bit is set. The block then returns to the running mode it left, and core_clk_en goes back to 1. A line with a clear wake_en bit has no effect.
- R7: A pulse on req_sleep gives mode 3 with core_pwr_en = 0, core_clk_en = 0 and pll_en = 0.
- R8: In SLEEP only enabled wake lines wake the block, and alarm_wake and irq_any are ignored. Line i is qualified by wake_cfg[2i+1:2i]: 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge.
- R9: While bfault_n = 0 in SLEEP, no wake line leaves SLEEP.
- R10: A wake from SLEEP holds int_rst at 1 for exactly 2^RST_W - 1 cycles. The lock phase follows the wake reset.
- R11: woke_from_sleep is set by a wake from SLEEP. A one-cycle pulse on wake_flag_clr clears it.
- R12: bfault_irq = 1 whenever bfault_irq_sel = 1 and bfault_n = 0 outside SLEEP and the wake reset. Inside those two it reads 0.
- R13: A req_idle or req_sleep pulse that arrives during the lock phase or the wake reset is held. It is carried out as soon as that count ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_slow | input | 1 | Level: select the slow clock source |
| req_pll_off | input | 1 | Level: turn the PLL off (honoured in SLOW only) |
| req_idle | input | 1 | Pulse: ask for IDLE |
| req_sleep | input | 1 | Pulse: ask for SLEEP |
| cpu_idle_ack | input | 1 | CPU confirms it is ready to have its clock stopped |
| lock_count | input | LOCK_W | PLL lock time in crystal cycles |
| irq_any | input | 1 | Any enabled interrupt pending (wakes IDLE) |
| alarm_wake | input | 1 | Alarm event (wakes IDLE) |
| wake_lines | input | N_WAKE | External wake inputs |
| wake_en | input | N_WAKE | Per-line wake enable |
| wake_cfg | input | 2*N_WAKE | Per-line qualifier code, two bits per line |
| bfault_n | input | 1 | Active-low battery fault |
| bfault_irq_sel | input | 1 | Route the battery fault to bfault_irq |
| wake_flag_clr | input | 1 | Write-one clear of woke_from_sleep |
| pll_en | output | 1 | PLL run enable |
| pll_stable | output | 1 | PLL on and its lock time elapsed |
| clk_sel_slow | output | 1 | 1 = slow source feeds the system clock |
| core_clk_en | output | 1 | Core clock gate |
| core_pwr_en | output | 1 | Core power domain enable |
| int_rst | output | 1 | Internal reset after a sleep wake |
| woke_from_sleep | output | 1 | Last power-up came from a sleep wake |
| bfault_irq | output | 1 | Low-level battery-fault interrupt |
| mode | output | 2 | Current mode code |

## Verification
The bench builds the block with N_WAKE = 16, LOCK_W = 8 and RST_W = 4. This shortens the wake reset to 15 cycles, so a full sleep, wake, reset and relock round trip can be repeated for every one of the sixteen wake lines. Each line uses the qualifier code equal to its index modulo four, and each round also tries a masked wake under a battery fault. The narrow lock counter allows a sweep of lock times that includes the zero and one corner cases, and the expected lock length is computed as max(L,1). A long lock time is also used to hold a pending idle request across the count.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_NORMAL,
        ST_SLOW,
        ST_IDLE_WAIT,
        ST_IDLE,
        ST_SLEEP,
        ST_WAKE_RST
    } pstate_t;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_SLOW   = 2'd1;
    localparam logic [1:0] MODE_IDLE   = 2'd2;
    localparam logic [1:0] MODE_SLEEP  = 2'd3;

    typedef enum logic [1:0] {
        WK_LOW  = 2'd0,
        WK_HIGH = 2'd1,
        WK_FALL = 2'd2,
        WK_RISE = 2'd3
    } wake_cfg_t;

endpackage

// File: rtl/pwr_span_timer.sv
// Elapsed-cycle counter: done rises in the cycle where the run has
// lasted max(limit,1) cycles; cleared whenever run is low.
module pwr_span_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W-1:0] cnt;

    assign done = run && (({1'b0, cnt} + ONE) >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_wake_qual.sv
// Per-line wake qualification (level or edge, either polarity) and
// battery-fault masking of the sleep wake.
module pwr_wake_qual
    import pwr_seq_pkg::*;
#(
    parameter int N_WAKE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_WAKE-1:0]   lines,
    input  logic [N_WAKE-1:0]   en,
    input  logic [2*N_WAKE-1:0] cfg,
    input  logic                alarm,
    input  logic                irq_any,
    input  logic                bfault_n,
    output logic                idle_wake,
    output logic                sleep_wake
);
    logic [N_WAKE-1:0] prev;
    logic [N_WAKE-1:0] hit;
    logic              line_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
        end else begin
            prev <= lines;
        end
    end

    for (genvar i = 0; i < N_WAKE; i++) begin : g_line
        wake_cfg_t code;
        assign code = wake_cfg_t'(cfg[2*i +: 2]);
        always_comb begin
            unique case (code)
                WK_LOW:  hit[i] = !lines[i];
                WK_HIGH: hit[i] = lines[i];
                WK_FALL: hit[i] = prev[i] && !lines[i];
                WK_RISE: hit[i] = !prev[i] && lines[i];
            endcase
        end
    end

    assign line_wake  = |(hit & en);
    assign idle_wake  = irq_any | alarm | line_wake;
    assign sleep_wake = line_wake & bfault_n;

    // R9: a battery fault never lets a wake through
    p_fault_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bfault_n |-> !sleep_wake);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int N_WAKE = 16,
    parameter int LOCK_W = 16,
    parameter int RST_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_slow,
    input  logic                req_pll_off,
    input  logic                req_idle,
    input  logic                req_sleep,
    input  logic                cpu_idle_ack,
    input  logic [LOCK_W-1:0]   lock_count,
    input  logic                irq_any,
    input  logic                alarm_wake,
    input  logic [N_WAKE-1:0]   wake_lines,
    input  logic [N_WAKE-1:0]   wake_en,
    input  logic [2*N_WAKE-1:0] wake_cfg,
    input  logic                bfault_n,
    input  logic                bfault_irq_sel,
    input  logic                wake_flag_clr,
    output logic                pll_en,
    output logic                pll_stable,
    output logic                clk_sel_slow,
    output logic                core_clk_en,
    output logic                core_pwr_en,
    output logic                int_rst,
    output logic                woke_from_sleep,
    output logic                bfault_irq,
    output logic [1:0]          mode
);
    localparam logic [RST_W-1:0] RST_SPAN = {RST_W{1'b1}};

    pstate_t state, nxt;
    logic    pll_on;
    logic    ret_slow;
    logic    pend_idle, pend_sleep;
    logic    woke_flag;
    logic    lock_done, wrst_done;
    logic    idle_wake, sleep_wake;
    logic    want_idle, want_sleep;
    logic    busy;

    pwr_span_timer #(.W(LOCK_W)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_LOCK),
        .limit (lock_count),
        .done  (lock_done)
    );

    pwr_span_timer #(.W(RST_W)) u_wrst (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAKE_RST),
        .limit (RST_SPAN),
        .done  (wrst_done)
    );

    pwr_wake_qual #(.N_WAKE(N_WAKE)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (wake_lines),
        .en         (wake_en),
        .cfg        (wake_cfg),
        .alarm      (alarm_wake),
        .irq_any    (irq_any),
        .bfault_n   (bfault_n),
        .idle_wake  (idle_wake),
        .sleep_wake (sleep_wake)
    );

    assign want_idle  = req_idle  | pend_idle;
    assign want_sleep = req_sleep | pend_sleep;
    assign busy       = (state == ST_LOCK) || (state == ST_WAKE_RST);

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCK: begin
                if (lock_done) nxt = req_slow ? ST_SLOW : ST_NORMAL;
            end
            ST_NORMAL: begin
                if (want_sleep)     nxt = ST_SLEEP;
                else if (want_idle) nxt = ST_IDLE_WAIT;
                else if (req_slow)  nxt = ST_SLOW;
            end
            ST_SLOW: begin
                if (want_sleep)                     nxt = ST_SLEEP;
                else if (want_idle)                 nxt = ST_IDLE_WAIT;
                else if (!pll_on && !req_pll_off)   nxt = ST_LOCK;
                else if (pll_on && !req_slow)       nxt = ST_NORMAL;
            end
            ST_IDLE_WAIT: begin
                if (cpu_idle_ack) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (idle_wake) nxt = ret_slow ? ST_SLOW : ST_NORMAL;
            end
            ST_SLEEP: begin
                if (sleep_wake) nxt = ST_WAKE_RST;
            end
            ST_WAKE_RST: begin
                if (wrst_done) nxt = ST_LOCK;
            end
        endcase
    end

    // State and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_LOCK;
            pll_on     <= 1'b1;
            ret_slow   <= 1'b0;
            pend_idle  <= 1'b0;
            pend_sleep <= 1'b0;
            woke_flag  <= 1'b0;
        end else begin
            state <= nxt;

            if (nxt == ST_LOCK) begin
                pll_on <= 1'b1;
            end else if (state == ST_SLOW && nxt == ST_SLOW && pll_on && req_pll_off) begin
                pll_on <= 1'b0;
            end

            if (state != ST_IDLE_WAIT && nxt == ST_IDLE_WAIT) begin
                ret_slow <= (state == ST_SLOW);
            end

            if (busy) begin
                if (req_idle)  pend_idle  <= 1'b1;
                if (req_sleep) pend_sleep <= 1'b1;
            end else if (nxt == ST_SLEEP || nxt == ST_IDLE_WAIT) begin
                pend_idle  <= 1'b0;
                pend_sleep <= 1'b0;
            end

            if (state == ST_SLEEP && nxt == ST_WAKE_RST) begin
                woke_flag <= 1'b1;
            end else if (wake_flag_clr) begin
                woke_flag <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        mode         = MODE_SLOW;
        clk_sel_slow = 1'b1;
        core_clk_en  = 1'b1;
        core_pwr_en  = 1'b1;
        int_rst      = 1'b0;
        pll_en       = pll_on;
        pll_stable   = pll_on;
        unique case (state)
            ST_LOCK: begin
                pll_stable = 1'b0;
            end
            ST_NORMAL: begin
                mode         = MODE_NORMAL;
                clk_sel_slow = 1'b0;
            end
            ST_SLOW: begin
                mode = MODE_SLOW;
            end
            ST_IDLE_WAIT: begin
                mode         = ret_slow ? MODE_SLOW : MODE_NORMAL;
                clk_sel_slow = ret_slow;
            end
            ST_IDLE: begin
                mode         = MODE_IDLE;
                clk_sel_slow = ret_slow;
                core_clk_en  = 1'b0;
            end
            ST_SLEEP: begin
                mode        = MODE_SLEEP;
                core_clk_en = 1'b0;
                core_pwr_en = 1'b0;
                pll_en      = 1'b0;
                pll_stable  = 1'b0;
            end
            ST_WAKE_RST: begin
                mode       = MODE_SLEEP;
                int_rst    = 1'b1;
                pll_en     = 1'b0;
                pll_stable = 1'b0;
            end
        endcase
    end

    assign woke_from_sleep = woke_flag;
    assign bfault_irq = bfault_irq_sel && !bfault_n &&
                        (state != ST_SLEEP) && (state != ST_WAKE_RST);

    // R4: the PLL is only ever switched off from SLOW
    p_pll_off_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_on) |-> $past(state) == ST_SLOW);

    // R5: IDLE is entered only after the CPU acknowledge
    p_idle_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) != ST_IDLE) |-> $past(cpu_idle_ack));

    // R9: a fault-masked sleep does not move
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !bfault_n) |=> state == ST_SLEEP);

    // R2: the lock phase holds until its timer completes
    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !lock_done) |=> state == ST_LOCK);

    // R10: internal reset persists until the wake timer completes
    p_rst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_RST && !wrst_done) |=> int_rst);

    // R11: the wake flag rises only out of SLEEP
    p_flag_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(woke_flag) |-> $past(state) == ST_SLEEP);

    // R3: full speed never runs without the PLL
    p_normal_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_NORMAL |-> pll_on);
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
    localparam int N_WAKE = 16;
    localparam int LOCK_W = 8;
    localparam int RST_W  = 4;
    localparam int RST_CYC = (1 << RST_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_slow, req_pll_off, req_idle, req_sleep, cpu_idle_ack;
    logic [LOCK_W-1:0]   lock_count;
    logic                irq_any, alarm_wake;
    logic [N_WAKE-1:0]   wake_lines, wake_en;
    logic [2*N_WAKE-1:0] wake_cfg;
    logic                bfault_n, bfault_irq_sel, wake_flag_clr;
    logic                pll_en, pll_stable, clk_sel_slow, core_clk_en, core_pwr_en;
    logic                int_rst, woke_from_sleep, bfault_irq;
    logic [1:0]          mode;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    pwr_mode_seq #(.N_WAKE(N_WAKE), .LOCK_W(LOCK_W), .RST_W(RST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_slow(req_slow), .req_pll_off(req_pll_off),
        .req_idle(req_idle), .req_sleep(req_sleep), .cpu_idle_ack(cpu_idle_ack),
        .lock_count(lock_count), .irq_any(irq_any), .alarm_wake(alarm_wake),
        .wake_lines(wake_lines), .wake_en(wake_en), .wake_cfg(wake_cfg),
        .bfault_n(bfault_n), .bfault_irq_sel(bfault_irq_sel), .wake_flag_clr(wake_flag_clr),
        .pll_en(pll_en), .pll_stable(pll_stable), .clk_sel_slow(clk_sel_slow),
        .core_clk_en(core_clk_en), .core_pwr_en(core_pwr_en), .int_rst(int_rst),
        .woke_from_sleep(woke_from_sleep), .bfault_irq(bfault_irq), .mode(mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_lock(output int n);
        n = 0;
        while (pll_en && !pll_stable && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic enter_idle();
        req_idle = 1'b1; cpu_idle_ack = 1'b1;
        tick(1);
        req_idle = 1'b0;
        tick(1);
        cpu_idle_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int lset [5] = '{0, 1, 2, 7, 20};
        rst_n = 0; req_slow = 0; req_pll_off = 0; req_idle = 0; req_sleep = 0;
        cpu_idle_ack = 0; lock_count = 5; irq_any = 0; alarm_wake = 0;
        wake_lines = '0; wake_en = '0; wake_cfg = '0; bfault_n = 1;
        bfault_irq_sel = 0; wake_flag_clr = 0;
        tick(3);
        // R1 reset state
        check("R1 mode", mode, 1);
        check("R1 clk_sel_slow", clk_sel_slow, 1);
        check("R1 pll_en", pll_en, 1);
        check("R1 pll_stable", pll_stable, 0);
        check("R1 core_clk_en", core_clk_en, 1);
        check("R1 core_pwr_en", core_pwr_en, 1);
        check("R1 int_rst", int_rst, 0);
        check("R1 woke", woke_from_sleep, 0);
        check("R1 bfault_irq", bfault_irq, 0);
        rst_n = 1;
        count_lock(n);
        check("R2 lock after reset", n, 5);
        check("R3 mode normal", mode, 0);
        check("R3 clk_sel normal", clk_sel_slow, 0);

        // R4: PLL-off ignored in NORMAL
        req_pll_off = 1; tick(3);
        check("R4 pll_en kept in normal", pll_en, 1);
        check("R4 mode kept", mode, 0);
        req_pll_off = 0;

        // R3: into SLOW
        req_slow = 1; tick(1);
        check("R3 mode slow", mode, 1);
        check("R3 clk_sel slow", clk_sel_slow, 1);

        // R2/R4 sweep over lock times
        foreach (lset[k]) begin
            lock_count = LOCK_W'(lset[k]);
            req_pll_off = 1; tick(1);
            check("R4 pll_en off in slow", pll_en, 0);
            req_slow = 0; tick(3);
            check("R4 stays slow with pll off", mode, 1);
            req_slow = 1; req_pll_off = 0; tick(1);
            count_lock(n);
            check("R2 relock length", n, (lset[k] == 0) ? 1 : lset[k]);
            check("R2 stable after lock", pll_stable, 1);
            check("R3 slow after lock", mode, 1);
            req_slow = 0; tick(1);
            check("R3 back to normal", mode, 0);
            req_slow = 1; tick(1);
        end
        req_slow = 0; tick(1);

        // R12 outside sleep
        bfault_irq_sel = 1; bfault_n = 0; tick(1);
        check("R12 irq in normal", bfault_irq, 1);
        bfault_irq_sel = 0; tick(1);
        check("R12 irq unselected", bfault_irq, 0);
        bfault_n = 1;

        // R5 idle handshake
        req_idle = 1; tick(1); req_idle = 0;
        tick(3);
        check("R5 clock on before ack", core_clk_en, 1);
        cpu_idle_ack = 1; tick(1); cpu_idle_ack = 0;
        check("R5 mode idle", mode, 2);
        check("R5 clock off", core_clk_en, 0);
        // R6: disabled line ignored
        wake_cfg[1:0] = 2'd1; wake_lines[0] = 1; tick(2);
        check("R6 disabled line ignored", mode, 2);
        wake_lines[0] = 0;
        irq_any = 1; tick(1); irq_any = 0;
        check("R6 irq exit", mode, 0);
        check("R6 clock back", core_clk_en, 1);
        enter_idle();
        check("R6 idle again", mode, 2);
        alarm_wake = 1; tick(1); alarm_wake = 0;
        check("R6 alarm exit", mode, 0);
        enter_idle();
        wake_en = 16'h0020; wake_cfg = '0; wake_cfg[11:10] = 2'd1;
        wake_lines[5] = 1; tick(1);
        check("R6 line exit", mode, 0);
        wake_lines[5] = 0; wake_en = '0;
        req_slow = 1; tick(1);
        enter_idle();
        check("R6 idle from slow clk_sel", clk_sel_slow, 1);
        irq_any = 1; tick(1); irq_any = 0;
        check("R6 return to slow", mode, 1);
        req_slow = 0; tick(1);

        // R7..R12 sleep sweep over all lines and qualifier codes
        lock_count = 3;
        bfault_irq_sel = 1;
        for (int i = 0; i < N_WAKE; i++) begin
            logic inact;
            inact = ((i % 4) % 2 == 0);
            wake_cfg = '0;
            wake_cfg[2*i +: 2] = 2'(i % 4);
            wake_en = '0; wake_en[i] = 1'b1;
            wake_lines = '0; wake_lines[i] = inact;
            tick(2);
            req_sleep = 1; tick(1); req_sleep = 0;
            check("R7 mode sleep", mode, 3);
            check("R7 core power off", core_pwr_en, 0);
            check("R7 core clock off", core_clk_en, 0);
            check("R7 pll off", pll_en, 0);
            alarm_wake = 1; irq_any = 1; tick(2);
            check("R8 alarm/irq ignored", mode, 3);
            alarm_wake = 0; irq_any = 0;
            bfault_n = 0; wake_lines[i] = !inact; tick(3);
            check("R9 fault masks wake", mode, 3);
            check("R12 no irq in sleep", bfault_irq, 0);
            wake_lines[i] = inact; tick(1);
            bfault_n = 1; tick(1);
            check("R8 inactive line keeps sleep", mode, 3);
            wake_lines[i] = !inact; tick(1);
            n = 0;
            while (int_rst && n < 1000) begin
                n++;
                @(negedge clk);
            end
            check("R10 wake reset length", n, RST_CYC);
            check("R11 flag set", woke_from_sleep, 1);
            count_lock(n);
            check("R10 lock after wake", n, 3);
            check("R10 normal after wake", mode, 0);
            wake_lines[i] = inact;
            wake_flag_clr = 1; tick(1); wake_flag_clr = 0;
            check("R11 flag cleared", woke_from_sleep, 0);
        end
        bfault_irq_sel = 0; wake_en = '0; wake_lines = '0;

        // R13: idle request held across a lock count
        lock_count = 20;
        req_slow = 1; tick(1);
        req_pll_off = 1; tick(1);
        req_pll_off = 0; tick(1);
        tick(2);
        req_idle = 1; tick(1); req_idle = 0;
        cpu_idle_ack = 1;
        check("R13 still locking", pll_stable, 0);
        check("R13 clock on during lock", core_clk_en, 1);
        count_lock(n);
        tick(3);
        check("R13 held idle served", mode, 2);
        cpu_idle_ack = 0;
        irq_any = 1; tick(1); irq_any = 0;
        check("R13 exit to slow", mode, 1);

        finish_run();
    end
endmodule